// File: doc/BRIEF.md
# Interleaved 4:2:2 Video Deinterleaver

This block takes progressive-scan YCbCr 4:2:2 video carried on one shared bus, where the samples repeat as Cb, Y, Cr, Y. It rebuilds chroma/luma pairs and presents each pair on a single 20-bit output word, together with a flag that tells Cb from Cr. It also finds the timing reference codes embedded in the stream. From those codes alone it recovers line-active, vertical-blanking and field state, so no separate sync wires are needed.

Capture works in one of two ways. In the double-rate mode, one sample arrives per clock cycle on the rising-edge lane. In the single-rate mode, the bus is sampled on both clock edges. This is modelled as two lanes, a rising-edge sample and a falling-edge sample, presented in the same cycle. A configuration bit then states which kind of sample sits on the rising edge. An 8-bit source may drive the upper eight bus bits, and the two lowest bits are then discarded.

Top module: `vid422_deint`

## Requirements
- R1: Each chroma/luma pair is presented as `pix_out = {Y, C}`, with luma in bits 19:10 and chroma in bits 9:0. The values are the input samples, unaltered apart from R5.
- R2: `chroma_is_cr` is 0 for Cb and 1 for Cr. It alternates on every output pair and restarts at Cb on the first pair after each start-of-active code (SAV).
- R3: In double-rate mode (`dual_edge_mode`=0), one sample is taken from `din_rise` each cycle. A sample equal to the reserved maximum code always begins a new pair, which realigns the pairing.
- R4: In single-rate mode (`dual_edge_mode`=1), two samples are taken each cycle, the rising-edge sample first. If `cb_on_rise`=1, the rising sample is chroma and the falling sample of the same cycle is its luma. If `cb_on_rise`=0, the rising sample is luma, and its chroma is the falling sample of the previous cycle.
- R5: In 8-bit mode (`narrow_mode`=1), input bits 1:0 are ignored and are output as 0. The reserved-code comparisons then use bits 9:2 only, with all ones as the maximum and all zeros as the minimum.
- R6: A timing reference is the word sequence maximum, minimum, minimum, XY, aligned to a chroma slot. In XY, bit 9 is 1, bit 8 is F, bit 7 is V and bit 6 is H. A code with H=0 (SAV) sets `h_active`. A code with H=1 (EAV) clears it. `v_blank` takes V and `field_id` takes F.
- R7: The XY protection bits 5,4,3,2 must equal V^H, F^H, F^V and F^V^H. If they do not, or if bit 9 is 0, `xy_error` pulses for one cycle and `h_active`, `v_blank` and `field_id` keep their values.
- R8: `pix_valid` pulses once per pair, and only while `h_active`=1 and `v_blank`=0. Timing-reference words are never output.
- R9: While `rst` is high, and on the cycle after it falls, the outputs show `h_active`=0, `v_blank`=1, `field_id`=0, `pix_valid`=0 and `xy_error`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dual_edge_mode | input | 1 | 1: two samples per cycle; 0: one sample per cycle |
| cb_on_rise | input | 1 | Single-rate mode: 1 = chroma on rising edge, 0 = luma on rising edge |
| narrow_mode | input | 1 | 1: 8-bit source on bits 9:2 |
| din_rise | input | 10 | Sample taken on the rising edge |
| din_fall | input | 10 | Sample taken on the falling edge (single-rate mode only) |
| pix_out | output | 20 | {luma, chroma} pair |
| chroma_is_cr | output | 1 | Chroma in `pix_out` is Cr when 1 |
| pix_valid | output | 1 | `pix_out` holds an active-video pair |
| h_active | output | 1 | Between SAV and EAV |
| v_blank | output | 1 | Vertical blanking flag from the last good code |
| field_id | output | 1 | Field flag from the last good code |
| xy_error | output | 1 | One-cycle pulse on a failed XY word |

## Verification
If the pairing phase goes wrong, chroma and luma come out swapped, or pairs straddle two groups, on the very next pair. The sweep catches this by comparing every output pair against arithmetically generated pixel values in all three capture arrangements. A missed or false timing-code detection shows up within one line, as extra, missing or misflagged pairs. The stream includes a line with an odd number of pairs, a vertically blanked line and a corrupted SAV word, so a stale chroma phase, leaking blanking data and an error that alters the state each surface as a count or flag mismatch.

// File: rtl/vid422_pkg.sv
package vid422_pkg;
  typedef enum logic {CH_CB = 1'b0, CH_CR = 1'b1} chroma_e;
  typedef struct packed {
    logic f;
    logic v;
    logic h;
  } trs_flags_t;
endpackage

// File: rtl/vid422_code_det.sv
module vid422_code_det #(
  parameter int DW      = 10,
  parameter int LSB_IGN = 2
) (
  input  logic [DW-1:0] smp,
  input  logic          narrow,
  output logic          is_max,
  output logic          is_min
);
  // Reserved-code compare; narrow sources only carry the upper bits.
  always_comb begin
    if (narrow) begin
      is_max = &smp[DW-1:LSB_IGN];
      is_min = ~|smp[DW-1:LSB_IGN];
    end else begin
      is_max = &smp;
      is_min = ~|smp;
    end
  end
endmodule

// File: rtl/vid422_pairer.sv
module vid422_pairer #(
  parameter int DW      = 10,
  parameter int LSB_IGN = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dual_edge,
  input  logic          cb_on_rise,
  input  logic          narrow,
  input  logic [DW-1:0] s_rise,
  input  logic [DW-1:0] s_fall,
  output logic          pair_vld,
  output logic [DW-1:0] pair_c,
  output logic [DW-1:0] pair_y
);
  localparam logic [DW-1:0] NARROW_MASK = {{(DW-LSB_IGN){1'b1}}, {LSB_IGN{1'b0}}};

  logic [DW-1:0] mask;
  logic [DW-1:0] r_m, f_m;
  logic          rise_max, rise_min;
  logic [DW-1:0] hold;
  logic          slot;
  logic [DW-1:0] prev_fall;
  logic          have_prev;

  assign mask = narrow ? NARROW_MASK : '1;
  assign r_m  = s_rise & mask;
  assign f_m  = s_fall & mask;

  vid422_code_det #(.DW(DW), .LSB_IGN(LSB_IGN)) u_rise_det (
    .smp(r_m), .narrow(narrow), .is_max(rise_max), .is_min(rise_min)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hold      <= '0;
      slot      <= 1'b0;
      prev_fall <= '0;
      have_prev <= 1'b0;
      pair_vld  <= 1'b0;
      pair_c    <= '0;
      pair_y    <= '0;
    end else begin
      pair_vld <= 1'b0;
      if (!dual_edge) begin
        // One sample per cycle; a maximum code forces the chroma slot.
        if (rise_max || !slot) begin
          hold <= r_m;
          slot <= 1'b1;
        end else begin
          pair_c   <= hold;
          pair_y   <= r_m;
          pair_vld <= 1'b1;
          slot     <= 1'b0;
        end
      end else if (cb_on_rise) begin
        pair_c   <= r_m;
        pair_y   <= f_m;
        pair_vld <= 1'b1;
      end else begin
        // Luma on the rising edge: chroma came on the previous falling edge.
        prev_fall <= f_m;
        have_prev <= 1'b1;
        if (have_prev) begin
          pair_c   <= prev_fall;
          pair_y   <= r_m;
          pair_vld <= 1'b1;
        end
      end
    end
  end

  logic unused_min;
  assign unused_min = rise_min;
endmodule

// File: rtl/vid422_trs_parser.sv
module vid422_trs_parser
  import vid422_pkg::*;
#(
  parameter int DW      = 10,
  parameter int LSB_IGN = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          narrow,
  input  logic          pair_vld,
  input  logic [DW-1:0] pair_c,
  input  logic [DW-1:0] pair_y,
  output logic [2*DW-1:0] pix_out,
  output logic          chroma_is_cr,
  output logic          pix_valid,
  output logic          h_active,
  output logic          v_blank,
  output logic          field_id,
  output logic          xy_error
);
  localparam int NLANE = 2;
  localparam int B_ONE = DW - 1;
  localparam int B_F   = DW - 2;
  localparam int B_V   = DW - 3;
  localparam int B_H   = DW - 4;
  localparam int B_P0  = DW - 8;

  logic [DW-1:0] lane [NLANE];
  logic [NLANE-1:0] l_max, l_min;

  assign lane[0] = pair_c;
  assign lane[1] = pair_y;

  for (genvar g = 0; g < NLANE; g++) begin : g_det
    vid422_code_det #(.DW(DW), .LSB_IGN(LSB_IGN)) u_det (
      .smp(lane[g]), .narrow(narrow), .is_max(l_max[g]), .is_min(l_min[g])
    );
  end

  trs_flags_t flg;
  logic [3:0] prot_exp;
  logic       xy_ok;
  logic       trs_pend;
  chroma_e    phase;

  always_comb begin
    flg.f    = pair_y[B_F];
    flg.v    = pair_y[B_V];
    flg.h    = pair_y[B_H];
    prot_exp = {flg.v ^ flg.h, flg.f ^ flg.h, flg.f ^ flg.v, flg.f ^ flg.v ^ flg.h};
    xy_ok    = l_min[0] && pair_y[B_ONE] && (pair_y[B_P0+3:B_P0] == prot_exp);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trs_pend     <= 1'b0;
      h_active     <= 1'b0;
      v_blank      <= 1'b1;
      field_id     <= 1'b0;
      xy_error     <= 1'b0;
      pix_valid    <= 1'b0;
      pix_out      <= '0;
      chroma_is_cr <= 1'b0;
      phase        <= CH_CB;
    end else begin
      pix_valid <= 1'b0;
      xy_error  <= 1'b0;
      if (pair_vld) begin
        if (trs_pend) begin
          trs_pend <= 1'b0;
          if (xy_ok) begin
            h_active <= ~flg.h;
            v_blank  <= flg.v;
            field_id <= flg.f;
            if (!flg.h) phase <= CH_CB;
          end else begin
            xy_error <= 1'b1;
          end
        end else if (l_max[0] && l_min[1]) begin
          trs_pend <= 1'b1;
        end else if (h_active && !v_blank) begin
          pix_valid    <= 1'b1;
          pix_out      <= {pair_y, pair_c};
          chroma_is_cr <= (phase == CH_CR);
          phase        <= (phase == CH_CB) ? CH_CR : CH_CB;
        end
      end
    end
  end

  logic unused_det;
  assign unused_det = l_max[1] ^ l_min[1] ^ l_max[0];
endmodule

// File: rtl/vid422_deint.sv
module vid422_deint #(
  parameter int DW      = 10,
  parameter int LSB_IGN = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            dual_edge_mode,
  input  logic            cb_on_rise,
  input  logic            narrow_mode,
  input  logic [DW-1:0]   din_rise,
  input  logic [DW-1:0]   din_fall,
  output logic [2*DW-1:0] pix_out,
  output logic            chroma_is_cr,
  output logic            pix_valid,
  output logic            h_active,
  output logic            v_blank,
  output logic            field_id,
  output logic            xy_error
);
  logic          pair_vld;
  logic [DW-1:0] pair_c, pair_y;

  vid422_pairer #(.DW(DW), .LSB_IGN(LSB_IGN)) u_pairer (
    .clk(clk), .rst(rst), .dual_edge(dual_edge_mode), .cb_on_rise(cb_on_rise),
    .narrow(narrow_mode), .s_rise(din_rise), .s_fall(din_fall),
    .pair_vld(pair_vld), .pair_c(pair_c), .pair_y(pair_y)
  );

  vid422_trs_parser #(.DW(DW), .LSB_IGN(LSB_IGN)) u_parser (
    .clk(clk), .rst(rst), .narrow(narrow_mode),
    .pair_vld(pair_vld), .pair_c(pair_c), .pair_y(pair_y),
    .pix_out(pix_out), .chroma_is_cr(chroma_is_cr), .pix_valid(pix_valid),
    .h_active(h_active), .v_blank(v_blank), .field_id(field_id), .xy_error(xy_error)
  );
endmodule

// File: rtl/vid422_deint_chk.sv
module vid422_deint_chk #(
  parameter int DW      = 10,
  parameter int LSB_IGN = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            narrow_mode,
  input logic [2*DW-1:0] pix_out,
  input logic            pix_valid,
  input logic            h_active,
  input logic            v_blank,
  input logic            field_id,
  input logic            xy_error
);
  // R8: pairs only inside active, unblanked video
  a_r8_valid_in_active: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> (h_active && !v_blank));

  // R8: a timing-reference opening pair never reaches the output
  a_r8_no_trs_out: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> !((&pix_out[DW-1:LSB_IGN]) && (~|pix_out[2*DW-1:DW+LSB_IGN])));

  // R7: a bad XY word leaves the timing state untouched
  a_r7_err_holds_state: assert property (@(posedge clk) disable iff (rst)
    xy_error |-> ($stable(h_active) && $stable(v_blank) && $stable(field_id)));

  // R7: error is a single-cycle pulse and never coincides with a pixel
  a_r7_err_single: assert property (@(posedge clk) disable iff (rst)
    xy_error |=> !xy_error);
  a_r7_err_no_pix: assert property (@(posedge clk) disable iff (rst)
    !(xy_error && pix_valid));

  // R5: low bits are zero on both lanes under a steady 8-bit setting
  a_r5_narrow_lsb_zero: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && narrow_mode && $past(narrow_mode) && $past(narrow_mode, 2)
     && $past(narrow_mode, 3) && $past(narrow_mode, 4))
    |-> ((~|pix_out[LSB_IGN-1:0]) && (~|pix_out[DW+LSB_IGN-1:DW])));

  // R9: state just out of reset
  a_r9_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!h_active && v_blank && !field_id && !pix_valid && !xy_error));
endmodule

bind vid422_deint vid422_deint_chk #(.DW(DW), .LSB_IGN(LSB_IGN)) u_chk (
  .clk(clk), .rst(rst), .narrow_mode(narrow_mode), .pix_out(pix_out),
  .pix_valid(pix_valid), .h_active(h_active), .v_blank(v_blank),
  .field_id(field_id), .xy_error(xy_error)
);

// File: tb/tb_vid422_deint.sv
module tb_vid422_deint;
  localparam int DW = 10;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            dual_edge_mode = 1'b0, cb_on_rise = 1'b0, narrow_mode = 1'b0;
  logic [DW-1:0]   din_rise = 10'h200, din_fall = 10'h200;
  logic [2*DW-1:0] pix_out;
  logic            chroma_is_cr, pix_valid, h_active, v_blank, field_id, xy_error;

  always #5 clk = ~clk;

  vid422_deint dut (
    .clk(clk), .rst(rst), .dual_edge_mode(dual_edge_mode), .cb_on_rise(cb_on_rise),
    .narrow_mode(narrow_mode), .din_rise(din_rise), .din_fall(din_fall),
    .pix_out(pix_out), .chroma_is_cr(chroma_is_cr), .pix_valid(pix_valid),
    .h_active(h_active), .v_blank(v_blank), .field_id(field_id), .xy_error(xy_error)
  );

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  logic [DW-1:0] smp [0:255];
  int n;
  logic [DW-1:0] ec [0:31];
  logic [DW-1:0] ey [0:31];
  bit ecr [0:31];
  int en, mon, errs;
  bit mon_en = 1'b0, saw_vb = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] msk(input logic [DW-1:0] v);
    return narrow_mode ? (v & 10'h3FC) : v;
  endfunction

  function automatic logic [DW-1:0] xyw(input bit f, input bit v, input bit h, input bit bad);
    logic [3:0] p;
    p = {v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    if (bad) p[0] = ~p[0];
    return {1'b1, f, v, h, p, 2'b00};
  endfunction

  task automatic push(input logic [DW-1:0] v);
    smp[n] = v;
    n++;
  endtask

  // Narrow sources get junk in the ignored low bits (R5)
  task automatic push_trs(input bit f, input bit v, input bit h, input bit bad);
    push(narrow_mode ? 10'h3FE : 10'h3FF);
    push(narrow_mode ? 10'h002 : 10'h000);
    push(narrow_mode ? 10'h001 : 10'h000);
    push(xyw(f, v, h, bad) | (narrow_mode ? 10'h002 : 10'h000));
  endtask

  task automatic push_line(input bit f, input bit v, input bit bad_sav, input int np,
                           input int lid);
    push_trs(f, v, 1'b1, 1'b0);
    for (int b = 0; b < 2; b++) begin
      push(10'h200);
      push(10'h040);
    end
    push_trs(f, v, 1'b0, bad_sav);
    for (int i = 0; i < np; i++) begin
      logic [DW-1:0] c, y;
      c = 10'(10'h105 + 37 * i + 11 * lid);
      y = 10'(10'h0C3 + 53 * i + 7 * lid);
      push(c);
      push(y);
      if (!v && !bad_sav) begin
        ec[en] = msk(c);
        ey[en] = msk(y);
        ecr[en] = i[0];
        en++;
      end
    end
  endtask

  function automatic logic [DW-1:0] get(input int i);
    return (i < n) ? smp[i] : 10'h200;
  endfunction

  // Output monitor: compare each pair with the expected list (R1, R2, R5)
  always @(negedge clk) begin
    if (mon_en && !rst) begin
      if (pix_valid) begin
        if (mon < en) begin
          chk(pix_out[DW-1:0] == ec[mon], "R1/R5 chroma", int'(pix_out[DW-1:0]), int'(ec[mon]));
          chk(pix_out[2*DW-1:DW] == ey[mon], "R1/R5 luma", int'(pix_out[2*DW-1:DW]), int'(ey[mon]));
          chk(chroma_is_cr == ecr[mon], "R2 chroma select", int'(chroma_is_cr), int'(ecr[mon]));
        end
        mon++;
      end
      if (xy_error) errs++;
      if (h_active && v_blank) saw_vb = 1'b1;
    end
  end

  task automatic run_cfg(input bit dual, input bit cbr, input bit nb, input string tag);
    dual_edge_mode = dual;
    cb_on_rise = cbr;
    narrow_mode = nb;
    din_rise = 10'h200;
    din_fall = 10'h200;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    chk(!h_active && v_blank && !field_id && !pix_valid && !xy_error, "R9 reset state",
        int'({h_active, v_blank, field_id, pix_valid, xy_error}), 5'b01000);
    n = 0; en = 0; mon = 0; errs = 0; saw_vb = 1'b0;
    push_line(1'b0, 1'b0, 1'b0, 3, 0);  // odd pair count: R2 restart next line
    push_line(1'b1, 1'b0, 1'b0, 4, 1);
    push_line(1'b1, 1'b1, 1'b0, 3, 2);  // vertical blanking: R8
    push_line(1'b1, 1'b0, 1'b1, 3, 3);  // corrupted SAV: R7
    push_trs(1'b1, 1'b0, 1'b1, 1'b0);   // closing EAV
    mon_en = 1'b1;
    if (!dual) begin
      for (int k = 0; k < n; k++) begin
        din_rise = smp[k];
        @(negedge clk);
      end
    end else if (cbr) begin
      for (int k = 0; k < n; k += 2) begin
        din_rise = smp[k];
        din_fall = smp[k + 1];
        @(negedge clk);
      end
    end else begin
      for (int j = 0; 2 * j - 1 < n; j++) begin
        din_rise = (j == 0) ? 10'h040 : get(2 * j - 1);
        din_fall = get(2 * j);
        @(negedge clk);
      end
    end
    din_rise = 10'h200;
    din_fall = 10'h200;
    repeat (12) @(negedge clk);
    mon_en = 1'b0;
    chk(mon == en, {"R3/R4/R8 pair count ", tag}, mon, en);
    chk(errs == 1, {"R7 error pulses ", tag}, errs, 1);
    chk(saw_vb, {"R6 v_blank seen ", tag}, int'(saw_vb), 1);
    chk(!h_active, {"R6 h_active after EAV ", tag}, int'(h_active), 0);
    chk(!v_blank, {"R6 v_blank final ", tag}, int'(v_blank), 0);
    chk(field_id, {"R6 field final ", tag}, int'(field_id), 1);
  endtask

  initial begin
    run_cfg(1'b0, 1'b0, 1'b0, "R3 double 10b");
    run_cfg(1'b0, 1'b0, 1'b1, "R3 double 8b");
    run_cfg(1'b1, 1'b1, 1'b0, "R4 cb-rise 10b");
    run_cfg(1'b1, 1'b0, 1'b0, "R4 y-rise 10b");
    run_cfg(1'b1, 1'b1, 1'b1, "R4 cb-rise 8b");
    run_cfg(1'b1, 1'b0, 1'b1, "R4 y-rise 8b");
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule